// File: doc/BRIEF.md
# Parallel Rational-Ratio Polyphase Resampler

This block is a fixed-ratio FIR resampler for datapaths that carry several samples on every clock. Each valid beat brings `P_IN` input samples and yields one beat of `Q_OUT` output samples. The output-to-input rate is therefore `Q_OUT/P_IN`. At elaboration this ratio is reduced to coprime factors: `L` (interpolation) and `M` (decimation). The two lane counts may share a common factor. The default is 6 in and 8 out, which gives L=4 and M=3.

Every output lane is wired to one fixed polyphase branch of a single prototype FIR of `N_TAP` taps. Because `Q_OUT*M/L` equals `P_IN`, the branch index and the newest input sample each lane reads are the same on every beat. Products that would multiply an implied stuffed zero are never built.

A short history register carries the most recent input samples from one beat to the next. This lets outputs at the start of a beat reach samples that arrived on earlier beats. The coefficients are a compile-time parameter.

Top module: `par_resampler`

## Requirements
- R1: Every beat accepted with `valid_i` high produces exactly one output beat of `Q_OUT` samples. No output beat appears without an accepted input beat.
- R2: `valid_o` is high exactly two clock cycles after the cycle in which `valid_i` was sampled high, and low otherwise.
- R3: Output sample m equals `sum_j h[j]*u[m*M-j]`, taken bit-exactly. Here `u` is the input stream with L-1 zeros inserted after each sample, and negative indices of `u` are zero. This means output m uses branch (m*M) mod L with taps h[k], h[k+L], and so on.
- R4: Input lane i, at bits `[i*DW +: DW]` of `data_i` on accepted beat c, is stream sample c*P_IN+i. Output lane q, at bits `[q*OW +: OW]` of `data_o`, is output sample c*Q_OUT+q. Lane 0 is the earliest sample in time.
- R5: An output whose filter span reaches back past the first lane of the current beat uses samples from earlier beats. A single nonzero sample in the last input lane appears in outputs of the following beats.
- R6: Cycles with `valid_i` low do not advance the stream. `data_i` is ignored on those cycles, and later results equal those of a stream with no gaps.
- R7: While `valid_o` is low, `data_o` keeps its previous value.
- R8: After `rst_ni` is asserted (active low, asynchronous), `valid_o` and `data_o` are 0. All input samples before the first accepted beat count as zero.
- R9: The sum is formed at full precision in `DW+CW+clog2(N_TAP)` bits. The output is bits `[SHIFT +: OW]` of that sum, which is an arithmetic right shift that rounds toward negative infinity.
- R10: Samples and coefficients are signed two's complement. Full-scale inputs of -2^(DW-1) and 2^(DW-1)-1 give the reference result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input beat strobe |
| data_i | input | P_IN*DW | Input samples, lane 0 earliest |
| valid_o | output | 1 | Output beat strobe |
| data_o | output | Q_OUT*OW | Output samples, lane 0 earliest |

## Verification
A single impulse in the first input lane exposes each branch's coefficients and shows whether the lanes are assigned in the right order. An impulse in the last lane can only reach later outputs through the history register, so it separates a correct carry between beats from a window that is cut off or shifted.

Full-scale and negative values expose faults in sign extension and in the final shift. Random streams sent back to back, and again with idle gaps filled with garbage data, compare the parallel structure against a serial zero-stuff, filter and decimate model. These runs catch errors in phase and index selection, and a stream that advances when it should hold. A reset in the middle of a run checks that the history is cleared.

// File: rtl/par_rs_pkg.sv
package par_rs_pkg;

  function automatic int gcd_f(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  // polyphase branch used by output lane q
  function automatic int phase_f(input int q, input int m, input int l);
    return (q * m) % l;
  endfunction

  // newest input lane (relative to the beat) read by output lane q
  function automatic int base_f(input int q, input int m, input int l);
    return (q * m) / l;
  endfunction

  function automatic int ntap_f(input int ph, input int n, input int l);
    return (n - ph + l - 1) / l;
  endfunction

endpackage

// File: rtl/par_rs_hist.sv
module par_rs_hist #(
  parameter int P_IN = 6,
  parameter int DW   = 8,
  parameter int HL   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [P_IN*DW-1:0]       data_i,
  output logic [(P_IN+HL)*DW-1:0]  win_o
);
  localparam int WW = (P_IN + HL) * DW;

  logic [HL*DW-1:0] hist_q;

  // window: oldest samples at the low end
  assign win_o = {data_i, hist_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (valid_i) hist_q <= win_o[WW-1 -: HL*DW];
  end

endmodule

// File: rtl/par_rs_lane.sv
module par_rs_lane #(
  parameter int N_TAP = 12,
  parameter int L     = 4,
  parameter int PH    = 0,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int OW    = 16,
  parameter int AW    = 20,
  parameter int SHIFT = 4,
  parameter logic [N_TAP*CW-1:0] COEF = '0,
  localparam int NT   = par_rs_pkg::ntap_f(PH, N_TAP, L)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_mul_i,
  input  logic              en_sum_i,
  input  logic [NT*DW-1:0]  taps_i,   // tap i: sample base-i
  output logic [OW-1:0]     y_o
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod_q [NT];
  logic signed [AW-1:0] acc;
  logic        [OW-1:0] y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NT; i++) prod_q[i] <= '0;
    end else if (en_mul_i) begin
      for (int i = 0; i < NT; i++)
        prod_q[i] <= PW'($signed(taps_i[i*DW +: DW])) *
                     PW'($signed(COEF[(PH + i*L)*CW +: CW]));
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NT; i++) acc = acc + AW'(prod_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else if (en_sum_i) y_q <= OW'(acc >>> SHIFT);
  end

  assign y_o = y_q;

endmodule

// File: rtl/par_resampler.sv
module par_resampler #(
  parameter int P_IN  = 6,
  parameter int Q_OUT = 8,
  parameter int N_TAP = 12,   // must exceed L
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int OW    = 16,
  parameter int SHIFT = 4,
  parameter logic [N_TAP*CW-1:0] COEF = 96'hFEFC0C1E323F37261407FD01
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [P_IN*DW-1:0]   data_i,
  output logic                 valid_o,
  output logic [Q_OUT*OW-1:0]  data_o
);
  import par_rs_pkg::*;

  localparam int G  = gcd_f(P_IN, Q_OUT);
  localparam int L  = Q_OUT / G;
  localparam int M  = P_IN / G;
  localparam int K  = (N_TAP + L - 1) / L;
  localparam int HL = K - 1;
  localparam int AW = DW + CW + $clog2(N_TAP);
  localparam int W  = P_IN + HL;

  logic [W*DW-1:0] win;
  logic            v_mul_q;
  logic            v_out_q;

  par_rs_hist #(.P_IN(P_IN), .DW(DW), .HL(HL)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (data_i),
    .win_o  (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_mul_q <= 1'b0;
      v_out_q <= 1'b0;
    end else begin
      v_mul_q <= valid_i;
      v_out_q <= v_mul_q;
    end
  end

  assign valid_o = v_out_q;

  for (genvar q = 0; q < Q_OUT; q++) begin : g_lane
    localparam int PH = phase_f(q, M, L);
    localparam int BS = base_f(q, M, L) + HL;
    localparam int NT = ntap_f(PH, N_TAP, L);

    logic [NT*DW-1:0] taps;

    for (genvar i = 0; i < NT; i++) begin : g_tap
      assign taps[i*DW +: DW] = win[(BS - i)*DW +: DW];
    end

    par_rs_lane #(
      .N_TAP(N_TAP), .L(L), .PH(PH), .DW(DW), .CW(CW),
      .OW(OW), .AW(AW), .SHIFT(SHIFT), .COEF(COEF)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_mul_i(valid_i),
      .en_sum_i(v_mul_q),
      .taps_i  (taps),
      .y_o     (data_o[q*OW +: OW])
    );
  end

endmodule

// File: rtl/par_rs_chk.sv
module par_rs_chk #(
  parameter int OBW = 128
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic           valid_o,
  input logic [OBW-1:0] data_o
);
  logic [1:0] age_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (valid_o) seen_q <= 1'b1;
    end
  end

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && valid_o) |-> $past(valid_i, 2));

  a_r2_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(valid_i, 2)) |-> valid_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && !valid_o) |-> $stable(data_o));

  a_r8_reset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !valid_o) |-> (data_o == '0));

endmodule

bind par_resampler par_rs_chk #(.OBW(Q_OUT*OW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .valid_o(valid_o),
  .data_o (data_o)
);

// File: tb/sim_par_resampler.sv
module sim_par_resampler;
  localparam int P = 6, Q = 8, N = 12, DW = 8, OW = 16, SHIFT = 4;
  localparam int L = 4, M = 3;
  localparam int H [N] = '{1, -3, 7, 20, 38, 55, 63, 50, 30, 12, -4, -2};

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [P*DW-1:0] data_i = '0;
  logic           valid_o;
  logic [Q*OW-1:0] data_o;

  always #10ns clk_i = ~clk_i;

  par_resampler u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .data_i(data_i), .valid_o(valid_o), .data_o(data_o)
  );

  int    n_chk = 0, n_fail = 0;
  int    xs[$];
  int    exp_q[$];
  int    beats_in = 0, beats_out = 0;
  string cur_req = "R4";
  logic  vi_d1 = 1'b0, vi_d2 = 1'b0;
  logic [Q*OW-1:0] last_o = '0;

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // serial reference: zero-stuff by L, filter, keep every M-th
  function automatic int ref_y(input int m);
    int acc;
    int n;
    logic signed [OW-1:0] t;
    acc = 0;
    for (int j = 0; j < N; j++) begin
      n = m * M - j;
      if (n >= 0 && n % L == 0 && n / L < xs.size()) acc += H[j] * xs[n / L];
    end
    t = OW'(acc >>> SHIFT);
    return int'(t);
  endfunction

  task automatic send(input int v[P]);
    for (int i = 0; i < P; i++) begin
      data_i[i*DW +: DW] = DW'(v[i]);
      xs.push_back(v[i]);
    end
    for (int q = 0; q < Q; q++) exp_q.push_back(ref_y(beats_in * Q + q));
    beats_in++;
    valid_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      data_i = (P*DW)'({$urandom(), $urandom()});  // ignored (R6)
      @(negedge clk_i);
    end
  endtask

  task automatic send_rand(input int lo, input int hi);
    int v[P];
    for (int i = 0; i < P; i++) v[i] = lo + int'($urandom_range(hi - lo));
    send(v);
  endtask

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vi_d1 <= 1'b0;
      vi_d2 <= 1'b0;
    end else begin
      vi_d1 <= valid_i;
      vi_d2 <= vi_d1;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o || vi_d2) chk("R2", int'(valid_o), int'(vi_d2), "valid_o latency");
      if (valid_o) begin
        if (exp_q.size() < Q) chk("R1", 1, 0, "output beat without input beat");
        else begin
          for (int q = 0; q < Q; q++)
            chk(cur_req, int'($signed(data_o[q*OW +: OW])), exp_q.pop_front(),
                $sformatf("lane %0d beat %0d", q, beats_out));
        end
        beats_out++;
        last_o = data_o;
      end else if (data_o !== last_o) begin
        chk("R7", 1, 0, "data_o changed while valid_o low");
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v[P];
    repeat (3) @(negedge clk_i);
    chk("R8", int'(valid_o), 0, "valid_o in reset");
    chk("R8", int'(data_o != '0), 0, "data_o in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4: impulse in lane 0 shows branch order per lane
    cur_req = "R4";
    v = '{64, 0, 0, 0, 0, 0};
    send(v);
    v = '{0, 0, 0, 0, 0, 0};
    send(v); send(v);
    idle(4);

    // R5: impulse in last lane reaches later beats through history
    cur_req = "R5";
    v = '{0, 0, 0, 0, 0, 100};
    send(v);
    v = '{0, 0, 0, 0, 0, 0};
    send(v); send(v);
    idle(4);

    // R10: full scale
    cur_req = "R10";
    v = '{-128, -128, -128, -128, -128, -128};
    send(v); send(v);
    v = '{127, 127, 127, 127, 127, 127};
    send(v); send(v);
    v = '{-128, 127, -128, 127, -128, 127};
    send(v);
    idle(4);

    // R9: small negatives exercise flooring shift
    cur_req = "R9";
    for (int k = 0; k < 6; k++) send_rand(-9, 2);
    idle(4);

    // R3: random back to back
    cur_req = "R3";
    for (int k = 0; k < 40; k++) send_rand(-128, 127);
    idle(4);

    // R6: gaps with garbage on data_i
    cur_req = "R6";
    for (int k = 0; k < 20; k++) begin
      send_rand(-128, 127);
      idle(1 + k % 3);
    end
    idle(4);

    chk("R1", beats_out, beats_in, "output beat count");
    chk("R1", exp_q.size(), 0, "pending expected samples");

    // R8: reset mid-run clears history
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R8", int'(valid_o), 0, "valid_o after reset");
    chk("R8", int'(data_o != '0), 0, "data_o after reset");
    xs.delete();
    beats_in = 0;
    beats_out = 0;
    last_o = '0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    cur_req = "R8";
    v = '{0, 0, 0, 0, 0, 0};
    send(v);
    v = '{50, -20, 0, 0, 0, 0};
    send(v);
    idle(4);
    chk("R1", beats_out, beats_in, "output beat count after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule